// File: doc/BRIEF.md
# Command dispatch router

The router executes the eight overloadable register-register command instructions of a processor core. A command carries an index `k` (0 to 7) and two operand words. The low 12 bits of the first operand name a logical unit chosen at run time. The router looks that unit up in a programmable table. Each table entry names one of several external device ports and a 12-bit subdevice number. The request is forwarded to that port together with a 15-bit selector equal to `subdevice | (k << 12)`, the full first operand including its upper data bits, and the second operand.

Two units are served inside the router and never reach a device. Unit 1 answers zero and unit 2 answers all ones, whatever the command index. Unit 0 and every unit without a table entry produce an illegal-instruction trap. A device that cannot serve a selector reports an error on its return channel, and the router hands this back to the core as a configuration-error trap. Only one command is in flight at a time: the core is stalled from acceptance until the response pulse has been delivered.

Top module: `cmd_router`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, no `dev_valid` bit is set and no table entry is valid.
- R2: The unit is `req_op1[11:0]`; unit 0 responds with `rsp_trap`=1, `rsp_cause`=1 (illegal instruction) and `rsp_data`=0, in the cycle after acceptance.
- R3: Unit 1 responds with data 0 and unit 2 with all ones, for every command index, with `rsp_trap`=0 and `rsp_cause`=0, in the cycle after acceptance, without raising any `dev_valid`.
- R4: A request to a mapped unit raises `dev_valid` on the configured port only, with `dev_sel` = `{k[2:0], subdevice[11:0]}` and the unmodified `req_op1` and `req_op2` words.
- R5: `dev_valid` and `dev_sel` hold steady until the device raises `dev_ready`.
- R6: After a port accepts, the first `dev_rvalid` from that port with `dev_rerr`=0 gives a response carrying its `dev_rdata`, with trap and cause 0, in the following cycle.
- R7: A `dev_rerr`=1 answer gives `rsp_trap`=1, `rsp_cause`=2 (configuration error) and `rsp_data`=0.
- R8: A unit with no valid entry, including any unit at or above `NUNITS`, responds like unit 0 (trap, cause 1).
- R9: `rsp_valid` is a one-cycle pulse; `req_ready` stays low from the cycle after acceptance until the cycle after the pulse.
- R10: A config write with `cfg_we`=1 to unit `u` (3 <= u < `NUNITS`) stores `cfg_map`, `cfg_port` and `cfg_sub`; `cfg_map`=0 removes the mapping; writes to units 0, 1, 2 and to units at or above `NUNITS` change nothing.
- R11: `dev_rvalid`, `dev_rerr` and `dev_rdata` of ports other than the selected one are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request from the core |
| req_ready | output | 1 | Router idle, request is taken this cycle |
| req_cmd | input | 3 | Command index k |
| req_op1 | input | XLEN | First operand, unit in bits 11:0 |
| req_op2 | input | XLEN | Second operand |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_data | output | XLEN | Result word |
| rsp_trap | output | 1 | Response is a trap |
| rsp_cause | output | 2 | 0 none, 1 illegal instruction, 2 configuration error |
| cfg_we | input | 1 | Table write strobe |
| cfg_unit | input | 12 | Unit to write |
| cfg_map | input | 1 | Entry valid bit |
| cfg_port | input | PW | Device port index |
| cfg_sub | input | 12 | Subdevice number |
| dev_valid | output | NPORTS | Request valid per port |
| dev_ready | input | NPORTS | Request accepted per port |
| dev_sel | output | NPORTS*15 | Selector per port, 15 bits each |
| dev_op1 | output | NPORTS*XLEN | First operand per port |
| dev_op2 | output | NPORTS*XLEN | Second operand per port |
| dev_rvalid | input | NPORTS | Answer valid per port |
| dev_rdata | input | NPORTS*XLEN | Answer data per port |
| dev_rerr | input | NPORTS | Answer is a configuration error |

## Verification
The assertions take for granted that devices raise `dev_rvalid` only after they have taken a request and that `cfg_port` never names a port at or above `NPORTS`. The stub devices in the bench answer exactly one cycle after their handshake and hold back `dev_ready` for a number of cycles equal to their port index. Spurious answers are injected only on ports that are not the target of the command in flight. Configuration writes are issued only while no command is outstanding, so the table is never rewritten under a lookup.

// File: rtl/cmd_router_pkg.sv
package cmd_router_pkg;

    localparam int UNIT_W = 12;
    localparam int SUB_W  = 12;
    localparam int CMD_W  = 3;
    localparam int SEL_W  = SUB_W + CMD_W;

    // built-in units; user units start above them
    localparam logic [UNIT_W-1:0] UNIT_NONE  = 12'd0;
    localparam logic [UNIT_W-1:0] UNIT_ZERO  = 12'd1;
    localparam logic [UNIT_W-1:0] UNIT_ONES  = 12'd2;
    localparam logic [UNIT_W-1:0] UNIT_FIRST = 12'd3;

    typedef enum logic [1:0] {
        CAUSE_NONE    = 2'd0,
        CAUSE_ILLEGAL = 2'd1,
        CAUSE_CFGERR  = 2'd2
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_RESP  = 2'd3
    } state_e;

endpackage

// File: rtl/cmd_router_fallback.sv
module cmd_router_fallback
    import cmd_router_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [UNIT_W-1:0] unit,
    output logic              hit,
    output logic [XLEN-1:0]   data
);

    always_comb begin
        hit  = (unit == UNIT_ZERO) || (unit == UNIT_ONES);
        data = (unit == UNIT_ONES) ? {XLEN{1'b1}} : '0;
    end

endmodule

// File: rtl/cmd_router_table.sv
module cmd_router_table
    import cmd_router_pkg::*;
#(
    parameter int NUNITS = 64,
    parameter int PW     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [UNIT_W-1:0] wr_unit,
    input  logic              wr_map,
    input  logic [PW-1:0]     wr_port,
    input  logic [SUB_W-1:0]  wr_sub,
    input  logic [UNIT_W-1:0] rd_unit,
    output logic              rd_hit,
    output logic [PW-1:0]     rd_port,
    output logic [SUB_W-1:0]  rd_sub
);

    localparam int IW = (NUNITS > 1) ? $clog2(NUNITS) : 1;

    typedef struct packed {
        logic             map;
        logic [PW-1:0]    port;
        logic [SUB_W-1:0] sub;
    } entry_t;

    entry_t tbl_q [NUNITS];
    entry_t tbl_d [NUNITS];
    logic   wr_ok;
    logic   rd_in_range;
    entry_t rd_ent;

    always_comb begin
        tbl_d = tbl_q;
        wr_ok = wr_en && (wr_unit >= UNIT_FIRST) && (32'(wr_unit) < NUNITS);
        if (wr_ok) begin
            tbl_d[wr_unit[IW-1:0]] = '{map: wr_map, port: wr_port, sub: wr_sub};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUNITS; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    always_comb begin
        rd_in_range = 32'(rd_unit) < NUNITS;
        rd_ent      = tbl_q[rd_unit[IW-1:0]];
        rd_hit      = rd_in_range && rd_ent.map;
        rd_port     = rd_ent.port;
        rd_sub      = rd_ent.sub;
    end

endmodule

// File: rtl/cmd_router_ports.sv
module cmd_router_ports
    import cmd_router_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int XLEN   = 64,
    parameter int PW     = 2
) (
    input  logic                     issue,
    input  logic                     listen,
    input  logic [PW-1:0]            port,
    input  logic [SEL_W-1:0]         sel,
    input  logic [XLEN-1:0]          op1,
    input  logic [XLEN-1:0]          op2,
    output logic [NPORTS-1:0]        dev_valid,
    input  logic [NPORTS-1:0]        dev_ready,
    output logic [NPORTS*SEL_W-1:0]  dev_sel,
    output logic [NPORTS*XLEN-1:0]   dev_op1,
    output logic [NPORTS*XLEN-1:0]   dev_op2,
    input  logic [NPORTS-1:0]        dev_rvalid,
    input  logic [NPORTS*XLEN-1:0]   dev_rdata,
    input  logic [NPORTS-1:0]        dev_rerr,
    output logic                     pick_ready,
    output logic                     pick_rvalid,
    output logic [XLEN-1:0]          pick_rdata,
    output logic                     pick_rerr
);

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        assign dev_valid[i]                 = issue && (port == PW'(i));
        assign dev_sel[i*SEL_W +: SEL_W]    = sel;
        assign dev_op1[i*XLEN +: XLEN]      = op1;
        assign dev_op2[i*XLEN +: XLEN]      = op2;
    end

    always_comb begin
        pick_ready  = 1'b0;
        pick_rvalid = 1'b0;
        pick_rdata  = '0;
        pick_rerr   = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (port == PW'(i)) begin
                pick_ready  = issue && dev_ready[i];
                pick_rvalid = listen && dev_rvalid[i];
                pick_rdata  = dev_rdata[i*XLEN +: XLEN];
                pick_rerr   = dev_rerr[i];
            end
        end
    end

endmodule

// File: rtl/cmd_router.sv
module cmd_router
    import cmd_router_pkg::*;
#(
    parameter int XLEN   = 64,
    parameter int NPORTS = 4,
    parameter int NUNITS = 64,
    parameter int PW     = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [2:0]               req_cmd,
    input  logic [XLEN-1:0]          req_op1,
    input  logic [XLEN-1:0]          req_op2,
    output logic                     rsp_valid,
    output logic [XLEN-1:0]          rsp_data,
    output logic                     rsp_trap,
    output logic [1:0]               rsp_cause,
    input  logic                     cfg_we,
    input  logic [11:0]              cfg_unit,
    input  logic                     cfg_map,
    input  logic [PW-1:0]            cfg_port,
    input  logic [11:0]              cfg_sub,
    output logic [NPORTS-1:0]        dev_valid,
    input  logic [NPORTS-1:0]        dev_ready,
    output logic [NPORTS*15-1:0]     dev_sel,
    output logic [NPORTS*XLEN-1:0]   dev_op1,
    output logic [NPORTS*XLEN-1:0]   dev_op2,
    input  logic [NPORTS-1:0]        dev_rvalid,
    input  logic [NPORTS*XLEN-1:0]   dev_rdata,
    input  logic [NPORTS-1:0]        dev_rerr
);

    typedef struct packed {
        state_e           state;
        logic [PW-1:0]    port;
        logic [SEL_W-1:0] sel;
        logic [XLEN-1:0]  op1;
        logic [XLEN-1:0]  op2;
        logic [XLEN-1:0]  data;
        logic             trap;
        cause_e           cause;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [UNIT_W-1:0] unit;
    logic              fb_hit;
    logic [XLEN-1:0]   fb_data;
    logic              tb_hit;
    logic [PW-1:0]     tb_port;
    logic [SUB_W-1:0]  tb_sub;
    logic              pick_ready;
    logic              pick_rvalid;
    logic [XLEN-1:0]   pick_rdata;
    logic              pick_rerr;

    assign unit = req_op1[UNIT_W-1:0];

    cmd_router_fallback #(.XLEN(XLEN)) u_fallback (
        .unit (unit),
        .hit  (fb_hit),
        .data (fb_data)
    );

    cmd_router_table #(.NUNITS(NUNITS), .PW(PW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_unit (cfg_unit),
        .wr_map  (cfg_map),
        .wr_port (cfg_port),
        .wr_sub  (cfg_sub),
        .rd_unit (unit),
        .rd_hit  (tb_hit),
        .rd_port (tb_port),
        .rd_sub  (tb_sub)
    );

    cmd_router_ports #(.NPORTS(NPORTS), .XLEN(XLEN), .PW(PW)) u_ports (
        .issue       (ctx_q.state == ST_ISSUE),
        .listen      (ctx_q.state == ST_WAIT),
        .port        (ctx_q.port),
        .sel         (ctx_q.sel),
        .op1         (ctx_q.op1),
        .op2         (ctx_q.op2),
        .dev_valid   (dev_valid),
        .dev_ready   (dev_ready),
        .dev_sel     (dev_sel),
        .dev_op1     (dev_op1),
        .dev_op2     (dev_op2),
        .dev_rvalid  (dev_rvalid),
        .dev_rdata   (dev_rdata),
        .dev_rerr    (dev_rerr),
        .pick_ready  (pick_ready),
        .pick_rvalid (pick_rvalid),
        .pick_rdata  (pick_rdata),
        .pick_rerr   (pick_rerr)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctx_d.op1   = req_op1;
                    ctx_d.op2   = req_op2;
                    ctx_d.data  = '0;
                    ctx_d.trap  = 1'b0;
                    ctx_d.cause = CAUSE_NONE;
                    if (fb_hit) begin
                        ctx_d.data  = fb_data;
                        ctx_d.state = ST_RESP;
                    end else if (tb_hit) begin
                        ctx_d.port  = tb_port;
                        ctx_d.sel   = {req_cmd, tb_sub};
                        ctx_d.state = ST_ISSUE;
                    end else begin
                        ctx_d.trap  = 1'b1;
                        ctx_d.cause = CAUSE_ILLEGAL;
                        ctx_d.state = ST_RESP;
                    end
                end
            end
            ST_ISSUE: begin
                if (pick_ready) begin
                    ctx_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (pick_rvalid) begin
                    if (pick_rerr) begin
                        ctx_d.trap  = 1'b1;
                        ctx_d.cause = CAUSE_CFGERR;
                        ctx_d.data  = '0;
                    end else begin
                        ctx_d.data  = pick_rdata;
                    end
                    ctx_d.state = ST_RESP;
                end
            end
            default: begin
                ctx_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_q <= '{state: ST_IDLE, cause: CAUSE_NONE, default: '0};
        end else begin
            ctx_q <= ctx_d;
        end
    end

    assign req_ready = (ctx_q.state == ST_IDLE);
    assign rsp_valid = (ctx_q.state == ST_RESP);
    assign rsp_data  = ctx_q.data;
    assign rsp_trap  = ctx_q.trap;
    assign rsp_cause = ctx_q.cause;

endmodule

// File: rtl/cmd_router_chk.sv
module cmd_router_chk #(
    parameter int XLEN   = 64,
    parameter int NPORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [XLEN-1:0]      req_op1,
    input logic                 rsp_valid,
    input logic [XLEN-1:0]      rsp_data,
    input logic                 rsp_trap,
    input logic [1:0]           rsp_cause,
    input logic [NPORTS-1:0]    dev_valid,
    input logic [NPORTS-1:0]    dev_ready,
    input logic [NPORTS*15-1:0] dev_sel
);

    // R1: a port is never driven while the router claims to be idle
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_valid != '0) |-> !req_ready);

    // R2: unit 0 traps as illegal in the next cycle
    assert_unit0_trap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op1[11:0] == 12'd0)
        |=> (rsp_valid && rsp_trap && rsp_cause == 2'd1 && rsp_data == '0));

    // R3: unit 1 answers zero in the next cycle
    assert_unit1_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op1[11:0] == 12'd1)
        |=> (rsp_valid && !rsp_trap && rsp_data == '0));

    // R3: unit 2 answers all ones in the next cycle
    assert_unit2_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op1[11:0] == 12'd2)
        |=> (rsp_valid && !rsp_trap && rsp_data == {XLEN{1'b1}}));

    // R4: at most one port is addressed
    assert_one_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_valid));

    // R5: request held until taken
    assert_hold_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_valid & ~dev_ready) != '0) |=> ($stable(dev_valid) && $stable(dev_sel)));

    // R7: cause matches the trap flag
    assert_cause_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_trap ? (rsp_cause == 2'd1 || rsp_cause == 2'd2) : (rsp_cause == 2'd0)));

    // R9: response is a single pulse
    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: no new request while a response is out
    assert_busy_on_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

endmodule

bind cmd_router cmd_router_chk #(.XLEN(XLEN), .NPORTS(NPORTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op1   (req_op1),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rsp_trap  (rsp_trap),
    .rsp_cause (rsp_cause),
    .dev_valid (dev_valid),
    .dev_ready (dev_ready),
    .dev_sel   (dev_sel)
);

// File: tb/cmd_router_tb.sv
module cmd_router_tb;

    localparam int XLEN = 64;
    localparam int NP   = 4;
    localparam int NU   = 64;
    localparam int PW   = 2;
    localparam int DW   = XLEN - 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 req_valid = 1'b0;
    logic                 req_ready;
    logic [2:0]           req_cmd = '0;
    logic [XLEN-1:0]      req_op1 = '0;
    logic [XLEN-1:0]      req_op2 = '0;
    logic                 rsp_valid;
    logic [XLEN-1:0]      rsp_data;
    logic                 rsp_trap;
    logic [1:0]           rsp_cause;
    logic                 cfg_we = 1'b0;
    logic [11:0]          cfg_unit = '0;
    logic                 cfg_map = 1'b0;
    logic [PW-1:0]        cfg_port = '0;
    logic [11:0]          cfg_sub = '0;
    logic [NP-1:0]        dev_valid;
    logic [NP-1:0]        dev_ready;
    logic [NP*15-1:0]     dev_sel;
    logic [NP*XLEN-1:0]   dev_op1;
    logic [NP*XLEN-1:0]   dev_op2;
    logic [NP-1:0]        dev_rvalid;
    logic [NP*XLEN-1:0]   dev_rdata;
    logic [NP-1:0]        dev_rerr;
    logic [NP-1:0]        noise = '0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    cmd_router #(.XLEN(XLEN), .NPORTS(NP), .NUNITS(NU)) u_dut (.*);

    function automatic logic [XLEN-1:0] stub_f(int p, logic [14:0] s,
                                               logic [XLEN-1:0] a, logic [XLEN-1:0] b);
        return a + (b ^ XLEN'(s)) + (XLEN'(p) << 40);
    endfunction

    // stub devices: port p waits p cycles before ready, answers one cycle later;
    // subdevices 0x100 and above are not implemented
    for (genvar p = 0; p < NP; p++) begin : g_stub
        logic [3:0]      wcnt;
        logic            pend;
        logic [XLEN-1:0] pdata;
        logic            perr;
        assign dev_ready[p] = dev_valid[p] && (wcnt >= 4'(p));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                wcnt <= '0; pend <= 1'b0; pdata <= '0; perr <= 1'b0;
            end else begin
                wcnt <= (dev_valid[p] && !dev_ready[p]) ? wcnt + 4'd1 : 4'd0;
                pend <= dev_valid[p] && dev_ready[p];
                if (dev_valid[p] && dev_ready[p]) begin
                    pdata <= stub_f(p, dev_sel[p*15 +: 15], dev_op1[p*XLEN +: XLEN],
                                    dev_op2[p*XLEN +: XLEN]);
                    perr  <= dev_sel[p*15 +: 12] >= 12'h100;
                end
            end
        end
        assign dev_rvalid[p]            = pend | noise[p];
        assign dev_rerr[p]              = pend ? perr : 1'b1;
        assign dev_rdata[p*XLEN +: XLEN] = pend ? pdata : {(XLEN/16){16'hBAD0}};
    end

    // bench model of the table
    logic          m_map  [NU];
    logic [PW-1:0] m_port [NU];
    logic [11:0]   m_sub  [NU];

    typedef struct packed {
        logic [XLEN-1:0] data;
        logic            trap;
        logic [1:0]      cause;
    } rexp_t;
    typedef struct packed {
        logic [PW-1:0]   port;
        logic [14:0]     sel;
        logic [XLEN-1:0] op1;
        logic [XLEN-1:0] op2;
    } dexp_t;

    rexp_t rq[$];
    string rtag[$];
    dexp_t dq[$];
    string dtag[$];

    task automatic chk(bit ok, string tag, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // response monitor
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (rq.size() == 0) begin
                chk(1'b0, "R9 unexpected response", XLEN'(rsp_valid), '0);
            end else begin
                rexp_t e;
                string t;
                e = rq.pop_front();
                t = rtag.pop_front();
                chk(rsp_data == e.data && rsp_trap == e.trap && rsp_cause == e.cause, t,
                    {rsp_data[XLEN-4:0], rsp_trap, rsp_cause},
                    {e.data[XLEN-4:0], e.trap, e.cause});
            end
        end
    end

    // device-side monitor
    always @(negedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NP; p++) begin
                if (dev_valid[p] && dev_ready[p]) begin
                    if (dq.size() == 0) begin
                        chk(1'b0, "R4 unexpected device request", XLEN'(p), '0);
                    end else begin
                        dexp_t e;
                        string t;
                        e = dq.pop_front();
                        t = dtag.pop_front();
                        chk(PW'(p) == e.port && dev_sel[p*15 +: 15] == e.sel, {t, " port/sel"},
                            XLEN'({PW'(p), dev_sel[p*15 +: 15]}), XLEN'({e.port, e.sel}));
                        chk(dev_op1[p*XLEN +: XLEN] == e.op1 && dev_op2[p*XLEN +: XLEN] == e.op2,
                            {t, " operands"}, dev_op1[p*XLEN +: XLEN] ^ dev_op2[p*XLEN +: XLEN],
                            e.op1 ^ e.op2);
                    end
                end
            end
        end
    end

    function automatic logic [XLEN-1:0] mk_op1(logic [11:0] unit, int salt);
        return {DW'(salt * 32'h9E37_79B9) ^ DW'(64'hC0FF_EE00_1234_5678), unit};
    endfunction

    task automatic cfg(logic [11:0] unit, logic map, logic [PW-1:0] port, logic [11:0] sub);
        @(negedge clk);
        cfg_we = 1'b1; cfg_unit = unit; cfg_map = map; cfg_port = port; cfg_sub = sub;
        if (unit >= 12'd3 && 32'(unit) < NU) begin
            m_map[unit] = map; m_port[unit] = port; m_sub[unit] = sub;
        end
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(logic [2:0] k, logic [XLEN-1:0] a, logic [XLEN-1:0] b, string tag);
        logic [11:0] u;
        rexp_t e;
        u = a[11:0];
        if (u == 12'd1) begin
            e = '{data: '0, trap: 1'b0, cause: 2'd0};
        end else if (u == 12'd2) begin
            e = '{data: '1, trap: 1'b0, cause: 2'd0};
        end else if (32'(u) < NU && m_map[u]) begin
            dexp_t d;
            d = '{port: m_port[u], sel: {k, m_sub[u]}, op1: a, op2: b};
            dq.push_back(d);
            dtag.push_back(tag);
            if (m_sub[u] >= 12'h100) e = '{data: '0, trap: 1'b1, cause: 2'd2};
            else e = '{data: stub_f(int'(m_port[u]), {k, m_sub[u]}, a, b), trap: 1'b0, cause: 2'd0};
        end else begin
            e = '{data: '0, trap: 1'b1, cause: 2'd1};
        end
        rq.push_back(e);
        rtag.push_back(tag);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = k; req_op1 = a; req_op2 = b;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        int n = 0;
        while ((rq.size() != 0 || dq.size() != 0) && n < 200) begin
            @(negedge clk);
            n++;
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        for (int i = 0; i < NU; i++) begin
            m_map[i] = 1'b0; m_port[i] = '0; m_sub[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0 && dev_valid == '0, "R1 reset outputs",
            XLEN'({req_ready, rsp_valid, dev_valid}), XLEN'({1'b1, 1'b0, NP'(0)}));

        // R1/R8: every user unit starts unmapped
        send(3'd0, mk_op1(12'd3, 1), 64'h11, "R1 empty table traps unit 3");
        send(3'd5, mk_op1(12'd63, 2), 64'h22, "R1 empty table traps unit 63");
        // R2
        send(3'd3, mk_op1(12'd0, 3), 64'h33, "R2 unit 0 illegal");
        // R8
        send(3'd1, mk_op1(12'd64, 4), 64'h44, "R8 unit at NUNITS");
        send(3'd7, mk_op1(12'hFFF, 5), 64'h55, "R8 unit 4095");

        // R3: fallbacks for every command index
        for (int k = 0; k < 8; k++) begin
            send(3'(k), mk_op1(12'd1, 10 + k), 64'hFFFF_0000_FFFF_0000, "R3 unit 1 zero");
            send(3'(k), mk_op1(12'd2, 20 + k), '0, "R3 unit 2 ones");
        end
        send(3'd4, mk_op1(12'd2, 30), 64'h1, "R3 unit 2 latency");
        chk(rsp_valid == 1'b1 && dev_valid == '0, "R3 response one cycle after accept, no port",
            XLEN'({rsp_valid, dev_valid}), XLEN'({1'b1, NP'(0)}));
        drain();

        // R10: reserved and out-of-range writes change nothing
        cfg(12'd0, 1'b1, 2'd0, 12'h005);
        cfg(12'd1, 1'b1, 2'd1, 12'h006);
        cfg(12'd2, 1'b1, 2'd2, 12'h007);
        cfg(12'd70, 1'b1, 2'd3, 12'h008);
        send(3'd2, mk_op1(12'd0, 40), 64'h9, "R10 write to unit 0 ignored");
        send(3'd2, mk_op1(12'd1, 41), 64'h9, "R10 write to unit 1 ignored");
        send(3'd2, mk_op1(12'd2, 42), 64'h9, "R10 write to unit 2 ignored");
        send(3'd2, mk_op1(12'd70, 43), 64'h9, "R10 write to unit 70 ignored");
        drain();

        // R4/R6: mapped units on every port
        cfg(12'd3,  1'b1, 2'd0, 12'h012);
        cfg(12'd4,  1'b1, 2'd1, 12'h0AB);
        cfg(12'd10, 1'b1, 2'd2, 12'h0FE);
        cfg(12'd63, 1'b1, 2'd3, 12'h033);
        cfg(12'd20, 1'b1, 2'd1, 12'h200);
        for (int k = 0; k < 8; k++) begin
            send(3'(k), mk_op1(12'd3, 50 + k), 64'hA000 + 64'(k), "R4 R6 unit 3 port 0");
            send(3'(k), mk_op1(12'd4, 60 + k), 64'hB000 + 64'(k), "R4 R6 unit 4 port 1");
            send(3'(k), mk_op1(12'd10, 70 + k), 64'hC000 + 64'(k), "R4 R6 unit 10 port 2");
            send(3'(k), mk_op1(12'd63, 80 + k), 64'hD000 + 64'(k), "R5 R6 unit 63 port 3");
        end
        // R7
        send(3'd6, mk_op1(12'd20, 90), 64'h77, "R7 device config error");

        // R9/R11: slow port with noise on the others
        drain();
        noise = 4'b0111;
        send(3'd3, mk_op1(12'd63, 91), 64'hE0E0, "R11 noise on other ports ignored");
        chk(req_ready == 1'b0, "R9 busy after accept", XLEN'(req_ready), '0);
        @(negedge clk);
        chk(req_ready == 1'b0, "R9 busy while device pending", XLEN'(req_ready), '0);
        drain();
        noise = '0;

        // R10: removing a mapping
        cfg(12'd4, 1'b0, 2'd1, 12'h0AB);
        send(3'd1, mk_op1(12'd4, 92), 64'h1, "R10 cleared entry traps");
        // R10: remap to another port
        cfg(12'd10, 1'b1, 2'd3, 12'h0C1);
        send(3'd5, mk_op1(12'd10, 93), 64'h2, "R10 remapped entry");
        drain();

        chk(rq.size() == 0 && dq.size() == 0, "R9 all responses delivered",
            XLEN'(rq.size() + dq.size()), '0);
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=0", rq.size());
            finish_run();
        end
    end

endmodule